// File: doc/BRIEF.md
# Seven-Segment Decoder Chain with Zero Suppression

This block turns a row of 4-bit BCD digits into active-high seven-segment drive patterns, one pattern per digit. Each digit stage has three overriding controls, evaluated in a fixed priority. The first is a per-digit forced blank. The second is a shared lamp test that lights every segment. The third is a ripple-blank input that dark-ens a zero digit only when the digit to its left was also dark.

Each stage exports an active-low ripple-blank status. The wrapper feeds that status into the next lower digit, so leading zeros disappear from the left. The least significant digit always shows, so the value zero still reads as "0". The whole chain is evaluated combinationally in one cycle, and the results are captured in registers that have a synchronous reset.

Top module: `seg_ripple_display`

## Requirements
- R1: When a digit's `blank_n_i` bit is low, all seven segments of that digit are off and its `rbo_n_q_o` bit is low, whatever the other inputs are.
- R2: When a digit's `blank_n_i` bit is high and `lamp_test_n_i` is low, all seven segments of that digit are on (7'h7F) and its `rbo_n_q_o` bit is high.
- R3: When a digit has forced blank and lamp test inactive, ripple-blank input low and code 0, all its segments are off and its `rbo_n_q_o` bit is low.
- R4: A code 0 with the ripple-blank input high shows the full zero pattern 7'h3F.
- R5: Each digit's 7-bit segment field is ordered {g,f,e,d,c,b,a}, with bit 0 = a. Codes 0 to 9 give 3F, 06, 5B, 4F, 66, 6D, 7C, 07, 7F, 67 (hex). Six is drawn without a, and nine is drawn without d.
- R6: Codes 10 to 15 give 58, 4C, 62, 69, 78 and 00 (hex).
- R7: Digit i occupies bits [7i+6:7i] of the segment bus and bits [4i+3:4i] of the BCD bus. Digit DIGITS-1 is the most significant and takes its ripple-blank input from `lead_blank_n_i`. Each other digit above 0 takes it from the status of the digit one place higher. Digit 0 has its ripple-blank input held high.
- R8: The outputs reflect the inputs from the previous rising clock edge. While `rst` is high at an edge, all segments are off and all `rbo_n_q_o` bits are high.
- R9: A digit's `rbo_n_q_o` bit is high in every case except the two covered by R1 and R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bcd_i | input | DIGITS*4 | Packed BCD digits, digit 0 in the low nibble |
| lamp_test_n_i | input | 1 | Active-low lamp test, shared by all digits |
| blank_n_i | input | DIGITS | Active-low forced blank, one bit per digit |
| lead_blank_n_i | input | 1 | Active-low ripple-blank input of the most significant digit |
| seg_q_o | output | DIGITS*7 | Registered segment drives, 7 bits per digit, active high |
| rbo_n_q_o | output | DIGITS | Registered active-low ripple-blank status per digit |

## Verification
The chain carries no state of its own, so a faulty stage shows up in the cycle right after the inputs that expose it. A wrong priority, glyph or chain link gives a segment field or status bit that differs from the model on the next sample. A wrong link is usually visible only for particular zero patterns, such as a zero below a non-zero digit or a forced blank above a zero. For that reason, a two-digit build is swept over every combination of codes and controls. A faulty reset shows in the very first sample.

// File: rtl/seg_pkg.sv
package seg_pkg;
    localparam int SEG_W  = 7;
    localparam int CODE_W = 4;

    typedef logic [SEG_W-1:0]  seg_t;
    typedef logic [CODE_W-1:0] code_t;

    localparam seg_t SEG_ALL_OFF = 7'h00;
    localparam seg_t SEG_ALL_ON  = 7'h7F;

    // Which rule decided a stage's output, highest priority first.
    typedef enum logic [1:0] {
        DEC_BLANK  = 2'd0,
        DEC_LAMP   = 2'd1,
        DEC_RIPPLE = 2'd2,
        DEC_GLYPH  = 2'd3
    } decide_t;
endpackage

// File: rtl/seg_glyph_rom.sv
module seg_glyph_rom
    import seg_pkg::*;
(
    input  code_t code_i,
    output seg_t  seg_o
);
    // Segment order {g,f,e,d,c,b,a}.
    always_comb begin
        unique case (code_i)
            4'd0:    seg_o = 7'h3F;
            4'd1:    seg_o = 7'h06;
            4'd2:    seg_o = 7'h5B;
            4'd3:    seg_o = 7'h4F;
            4'd4:    seg_o = 7'h66;
            4'd5:    seg_o = 7'h6D;
            4'd6:    seg_o = 7'h7C;
            4'd7:    seg_o = 7'h07;
            4'd8:    seg_o = 7'h7F;
            4'd9:    seg_o = 7'h67;
            4'd10:   seg_o = 7'h58;
            4'd11:   seg_o = 7'h4C;
            4'd12:   seg_o = 7'h62;
            4'd13:   seg_o = 7'h69;
            4'd14:   seg_o = 7'h78;
            default: seg_o = SEG_ALL_OFF;
        endcase
    end
endmodule

// File: rtl/seg_digit_stage.sv
module seg_digit_stage
    import seg_pkg::*;
(
    input  code_t code_i,
    input  logic  lamp_n_i,
    input  logic  rbi_n_i,
    input  logic  bi_n_i,
    output seg_t  seg_o,
    output logic  rbo_n_o
);
    seg_t    glyph;
    decide_t rule;

    seg_glyph_rom i_rom (
        .code_i (code_i),
        .seg_o  (glyph)
    );

    // Priority: forced blank, then lamp test, then ripple blank of a zero.
    always_comb begin
        if (!bi_n_i)                          rule = DEC_BLANK;
        else if (!lamp_n_i)                   rule = DEC_LAMP;
        else if (!rbi_n_i && code_i == '0)    rule = DEC_RIPPLE;
        else                                  rule = DEC_GLYPH;
    end

    always_comb begin
        unique case (rule)
            DEC_BLANK:  begin seg_o = SEG_ALL_OFF; rbo_n_o = 1'b0; end
            DEC_LAMP:   begin seg_o = SEG_ALL_ON;  rbo_n_o = 1'b1; end
            DEC_RIPPLE: begin seg_o = SEG_ALL_OFF; rbo_n_o = 1'b0; end
            default:    begin seg_o = glyph;       rbo_n_o = 1'b1; end
        endcase
    end
endmodule

// File: rtl/seg_ripple_display.sv
module seg_ripple_display
    import seg_pkg::*;
#(
    parameter int DIGITS = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [DIGITS*4-1:0]   bcd_i,
    input  logic                  lamp_test_n_i,
    input  logic [DIGITS-1:0]     blank_n_i,
    input  logic                  lead_blank_n_i,
    output logic [DIGITS*7-1:0]   seg_q_o,
    output logic [DIGITS-1:0]     rbo_n_q_o
);
    localparam int BUS_W = DIGITS * SEG_W;

    typedef struct packed {
        logic [BUS_W-1:0]  seg;
        logic [DIGITS-1:0] rbo_n;
    } disp_t;

    logic [DIGITS-1:0] rbi_n;
    logic [DIGITS-1:0] rbo_n;
    seg_t              stage_seg [DIGITS];
    disp_t             disp_d, disp_q;

    for (genvar g = 0; g < DIGITS; g++) begin : g_stage
        if (g == 0) begin : g_lsd
            assign rbi_n[g] = 1'b1;
        end else if (g == DIGITS - 1) begin : g_msd
            assign rbi_n[g] = lead_blank_n_i;
        end else begin : g_mid
            assign rbi_n[g] = rbo_n[g+1];
        end

        seg_digit_stage i_stage (
            .code_i   (bcd_i[g*CODE_W +: CODE_W]),
            .lamp_n_i (lamp_test_n_i),
            .rbi_n_i  (rbi_n[g]),
            .bi_n_i   (blank_n_i[g]),
            .seg_o    (stage_seg[g]),
            .rbo_n_o  (rbo_n[g])
        );
    end

    always_comb begin
        disp_d = disp_q;
        for (int k = 0; k < DIGITS; k++) begin
            disp_d.seg[k*SEG_W +: SEG_W] = stage_seg[k];
        end
        disp_d.rbo_n = rbo_n;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            disp_q.seg   <= '0;
            disp_q.rbo_n <= '1;
        end else begin
            disp_q <= disp_d;
        end
    end

    assign seg_q_o   = disp_q.seg;
    assign rbo_n_q_o = disp_q.rbo_n;
endmodule

// File: rtl/seg_ripple_display_chk.sv
module seg_ripple_display_chk #(
    parameter int DIGITS = 4
) (
    input logic                clk,
    input logic                rst,
    input logic [DIGITS*4-1:0] bcd_i,
    input logic                lamp_test_n_i,
    input logic [DIGITS-1:0]   blank_n_i,
    input logic                lead_blank_n_i,
    input logic [DIGITS*7-1:0] seg_q_o,
    input logic [DIGITS-1:0]   rbo_n_q_o
);
    // Set once an edge with reset low has loaded real inputs.
    logic live_q;
    always_ff @(posedge clk) begin
        if (rst) live_q <= 1'b0;
        else     live_q <= 1'b1;
    end

    p_reset_state_r8: assert property (@(posedge clk)
        $past(rst) |-> (seg_q_o == '0 && rbo_n_q_o == '1));

    for (genvar g = 0; g < DIGITS; g++) begin : g_dig
        p_forced_blank_r1: assert property (@(posedge clk) disable iff (rst)
            live_q && $past(!blank_n_i[g]) |->
                (seg_q_o[g*7 +: 7] == 7'h00 && !rbo_n_q_o[g]));

        p_lamp_test_r2: assert property (@(posedge clk) disable iff (rst)
            live_q && $past(blank_n_i[g] && !lamp_test_n_i) |->
                (seg_q_o[g*7 +: 7] == 7'h7F && rbo_n_q_o[g]));

        p_status_dark_r9: assert property (@(posedge clk) disable iff (rst)
            live_q && !rbo_n_q_o[g] |-> seg_q_o[g*7 +: 7] == 7'h00);

        if (g == 0) begin : g_lsd
            p_lsd_never_ripples_r7: assert property (@(posedge clk) disable iff (rst)
                live_q && $past(blank_n_i[0]) |-> rbo_n_q_o[0]);
        end else if (g < DIGITS - 1) begin : g_mid
            p_ripple_needs_upper_r7: assert property (@(posedge clk) disable iff (rst)
                live_q && $past(blank_n_i[g]) && !rbo_n_q_o[g] |-> !rbo_n_q_o[g+1]);
        end
    end
endmodule

bind seg_ripple_display seg_ripple_display_chk #(.DIGITS(DIGITS)) i_chk (
    .clk            (clk),
    .rst            (rst),
    .bcd_i          (bcd_i),
    .lamp_test_n_i  (lamp_test_n_i),
    .blank_n_i      (blank_n_i),
    .lead_blank_n_i (lead_blank_n_i),
    .seg_q_o        (seg_q_o),
    .rbo_n_q_o      (rbo_n_q_o)
);

// File: tb/test_seg_ripple_display.sv
module test_seg_ripple_display;
    localparam int N = 2;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [N*4-1:0] bcd = '0;
    logic           lt_n = 1'b1;
    logic [N-1:0]   bl_n = '1;
    logic           lead_n = 1'b1;
    logic [N*7-1:0] seg;
    logic [N-1:0]   rbo_n;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 1'b0;

    always #5 clk = ~clk;

    seg_ripple_display #(.DIGITS(N)) i_seg_ripple_display (
        .clk            (clk),
        .rst            (rst),
        .bcd_i          (bcd),
        .lamp_test_n_i  (lt_n),
        .blank_n_i      (bl_n),
        .lead_blank_n_i (lead_n),
        .seg_q_o        (seg),
        .rbo_n_q_o      (rbo_n)
    );

    function automatic logic [6:0] glyph(input logic [3:0] c);
        logic [6:0] p;
        case (c)
            0: p = 7'h3F;  1: p = 7'h06;  2: p = 7'h5B;  3: p = 7'h4F;
            4: p = 7'h66;  5: p = 7'h6D;  6: p = 7'h7C;  7: p = 7'h07;
            8: p = 7'h7F;  9: p = 7'h67; 10: p = 7'h58; 11: p = 7'h4C;
           12: p = 7'h62; 13: p = 7'h69; 14: p = 7'h78; default: p = 7'h00;
        endcase
        return p;
    endfunction

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h (bcd=%h lt=%b bl=%b lead=%b)",
                     req, got, exp, bcd, lt_n, bl_n, lead_n);
        end
    endtask

    // Model: walk from the most significant digit down, priority blank > lamp > ripple.
    task automatic check_all();
        logic rbi = lead_n;
        for (int d = N - 1; d >= 0; d--) begin
            logic [3:0] c = bcd[d*4 +: 4];
            logic [6:0] es;
            logic       er;
            string      tag;
            if (d == 0) rbi = 1'b1;                    // R7 lsd tied high
            if (!bl_n[d])                 begin es = 7'h00; er = 1'b0; tag = "R1"; end
            else if (!lt_n)               begin es = 7'h7F; er = 1'b1; tag = "R2"; end
            else if (!rbi && c == 4'd0)   begin es = 7'h00; er = 1'b0; tag = "R3"; end
            else begin
                es = glyph(c); er = 1'b1;
                tag = (c == 0) ? "R4" : (c < 10) ? "R5" : "R6";
            end
            check(tag, {1'b0, seg[d*7 +: 7]}, {1'b0, es});
            check((tag == "R1" || tag == "R3") ? tag : "R9", {7'b0, rbo_n[d]}, {7'b0, er});
            if (d < N - 1) check("R7", {7'b0, rbo_n[d]}, {7'b0, er});
            rbi = er;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        // R8 reset state
        bcd = 8'h88; lt_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R8", {1'b0, seg[6:0]}, 8'h00);
        check("R8", {1'b0, seg[13:7]}, 8'h00);
        check("R8", {6'b0, rbo_n}, 8'h03);
        rst = 1'b0;
        @(negedge clk);
        check("R8", {1'b0, seg[6:0]}, 8'h7F);   // one-cycle latency after release

        // Exhaustive sweep of codes and controls.
        for (int v = 0; v < 4096; v++) begin
            bcd    = v[7:0];
            lt_n   = v[8];
            bl_n   = v[10:9];
            lead_n = v[11];
            @(negedge clk);
            check_all();
        end

        // R8 reset in mid-run clears the outputs again.
        bcd = 8'h18; lt_n = 1'b1; bl_n = '1; lead_n = 1'b1;
        @(negedge clk);
        check("R5", {1'b0, seg[6:0]}, 8'h7F);
        rst = 1'b1;
        @(negedge clk);
        check("R8", {1'b0, seg[13:7]}, 8'h00);
        check("R8", {6'b0, rbo_n}, 8'h03);
        rst = 1'b0;
        @(negedge clk);
        finish_run();
    end
endmodule